// File: doc/BRIEF.md
# Shared Global Timer with Per-Core Comparators

This block holds one free-running 64-bit up-counter that every processor core in a cluster reads at the same time. Each core also gets its own comparator bank. A bank holds a 64-bit compare value, an auto-increment step, a sticky event flag and an interrupt line. Software reaches the block through a 32-bit register window of eight words. A core-select input picks which bank a transaction uses, so each core sees the same count but a private comparator, status and interrupt-enable set.

The counter runs while the shared enable is set. A shared prescale field divides the input clock before each count. A comparator fires when the count is at or beyond its value. The event sets that core's sticky flag, and the flag raises the core's interrupt when its interrupt enable is set. With auto-increment on, the event moves the comparator forward by whole multiples of the step until it lies just beyond the current count. This gives periodic ticks without software reloading the comparator.

Top module: `mc_global_timer`

## Requirements
- R1: The counter is 64 bits wide. Software reads and loads it as a low word at offset 0x00 and a high word at offset 0x04.
- R2: Control bit 0 is the shared run enable and bits 15:8 hold the prescale value P. While enabled, the counter rises by one every P+1 clock cycles. The prescale phase restarts from zero whenever the timer is stopped.
- R3: A write to either counter word while the run enable is set leaves the count untouched.
- R4: A core's compare event needs the run enable, that core's control bit 1 (compare enable), and a count greater than or equal to its comparator. The event sets bit 0 of that core's status word (offset 0x0C) on the next clock edge. The bit stays set until software clears it.
- R5: With control bit 3 (auto-increment) set and a nonzero step at offset 0x18, an event moves the comparator to the smallest value of the form comparator + k·step that exceeds the count seen at the event. This takes one cycle when the gap is below the step and 65 cycles otherwise. With auto-increment off or a zero step, the comparator does not move.
- R6: Each core's interrupt output is high exactly when its status bit and its control bit 2 (interrupt enable) are both set.
- R7: Writing the status word clears bit 0 when the written bit 0 is 1 and leaves it unchanged when the written bit is 0. An event in the same cycle as the clear wins.
- R8: Control bits 1, 2 and 3 are stored per core, and the core-select input chooses which copy a write updates. Bits 0 and 15:8 are shared by all cores. A control read returns the shared bits ORed with the selected core's bits.
- R9: A read returns zero when the byte address is not word aligned, when it hits offset 0x1C, or when the core select exceeds the core count. A write under any of those conditions changes nothing.
- R10: Reset clears the counter, the shared control, and every core's control bits, status, comparator and step.
- R11: Each core has its own comparator, low word at 0x10 and high word at 0x14, and its own 32-bit step at 0x18. All of these read back per core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Access strobe for this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte address inside the window |
| bus_wdata_i | input | DATA_W | Write data |
| bus_core_i | input | CORE_W | Index of the core making the access |
| bus_rdata_o | output | DATA_W | Read data, combinational from address and core |
| irq_o | output | NUM_CORES | Per-core interrupt lines |

## Verification
The bench builds the block with its defaults: two cores, 32-bit data and an 8-bit prescale field. Two cores are enough to show that one core's control, status, step and comparator writes never reach the other bank while both share a single count. The 8-bit prescale lets the bench stop the counter for up to 255 cycles. That covers the 65-cycle remainder path of auto-increment, so its result can be checked against a frozen count. A prescale of zero reaches the carry from the low counter word into the high word within a few cycles.

// File: rtl/gt_pkg.sv
package gt_pkg;

    // Word index inside the register window (byte address bits 4:2)
    localparam logic [2:0] W_CNT_LO  = 3'd0;
    localparam logic [2:0] W_CNT_HI  = 3'd1;
    localparam logic [2:0] W_CTRL    = 3'd2;
    localparam logic [2:0] W_STATUS  = 3'd3;
    localparam logic [2:0] W_CMP_LO  = 3'd4;
    localparam logic [2:0] W_CMP_HI  = 3'd5;
    localparam logic [2:0] W_STEP    = 3'd6;

    // Control word bit positions
    localparam int B_RUN      = 0;
    localparam int B_CMP_EN   = 1;
    localparam int B_IRQ_EN   = 2;
    localparam int B_AUTO     = 3;
    localparam int B_PRE_LSB  = 8;

    typedef struct packed {
        logic cmp_en;
        logic irq_en;
        logic auto_en;
    } bank_ctrl_t;

endpackage

// File: rtl/gt_counter.sv
module gt_counter #(
    parameter int DATA_W = 32,
    parameter int PRE_W  = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic [PRE_W-1:0]  presc_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run_i) begin
            if (st_q.pre == presc_i) begin
                st_d.pre = '0;
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
        end else begin
            st_d.pre = '0;
            if (wr_lo_i) begin
                st_d.cnt[DATA_W-1:0] = wdata_i;
            end
            if (wr_hi_i) begin
                st_d.cnt[CNT_W-1:DATA_W] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o)); // R2

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + CNT_W'(1))); // R3

endmodule

// File: rtl/gt_bank.sv
module gt_bank
    import gt_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W  = 2 * DATA_W,
    localparam int STEP_W = $clog2(CNT_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_stat_i,
    input  logic              wr_cmp_lo_i,
    input  logic              wr_cmp_hi_i,
    input  logic              wr_step_i,
    output bank_ctrl_t        ctrl_o,
    output logic              status_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [DATA_W-1:0] step_o,
    output logic              irq_o
);

    typedef struct packed {
        bank_ctrl_t        ctrl;
        logic              status;
        logic [CNT_W-1:0]  cmp;
        logic [DATA_W-1:0] step;
        logic              busy;
        logic [CNT_W-1:0]  dvd;
        logic [DATA_W-1:0] rem;
        logic [STEP_W-1:0] idx;
        logic [CNT_W-1:0]  target;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic              hit;
    logic [CNT_W-1:0]  gap;
    logic [CNT_W-1:0]  step_ext;
    logic              step_nz;
    logic [DATA_W:0]   rem_sh;
    logic [DATA_W:0]   rem_nx;
    logic              cmp_wr_any;

    assign step_ext   = CNT_W'(st_q.step);
    assign step_nz    = (st_q.step != '0);
    assign gap        = cnt_i - st_q.cmp;
    assign hit        = run_i && st_q.ctrl.cmp_en && (cnt_i >= st_q.cmp) && !st_q.busy;
    assign cmp_wr_any = wr_cmp_lo_i || wr_cmp_hi_i || wr_step_i;

    // One restoring remainder step: shift in the next gap bit, subtract if it fits
    always_comb begin
        rem_sh = {st_q.rem, st_q.dvd[CNT_W-1]};
        if (rem_sh >= {1'b0, st_q.step}) begin
            rem_nx = rem_sh - {1'b0, st_q.step};
        end else begin
            rem_nx = rem_sh;
        end
    end

    always_comb begin
        st_d = st_q;

        if (wr_ctrl_i) begin
            st_d.ctrl.cmp_en  = wdata_i[B_CMP_EN];
            st_d.ctrl.irq_en  = wdata_i[B_IRQ_EN];
            st_d.ctrl.auto_en = wdata_i[B_AUTO];
        end

        if (wr_stat_i && wdata_i[0]) begin
            st_d.status = 1'b0;
        end

        if (st_q.busy) begin
            st_d.rem = rem_nx[DATA_W-1:0];
            st_d.dvd = st_q.dvd << 1;
            st_d.idx = st_q.idx + STEP_W'(1);
            if (st_q.idx == STEP_W'(CNT_W - 1)) begin
                st_d.busy = 1'b0;
                st_d.cmp  = st_q.target - CNT_W'(rem_nx[DATA_W-1:0]);
            end
        end

        if (hit) begin
            st_d.status = 1'b1;
            if (st_q.ctrl.auto_en && step_nz) begin
                if (gap < step_ext) begin
                    st_d.cmp = st_q.cmp + step_ext;
                end else begin
                    st_d.busy   = 1'b1;
                    st_d.dvd    = gap;
                    st_d.rem    = '0;
                    st_d.idx    = '0;
                    st_d.target = cnt_i + step_ext;
                end
            end
        end

        if (cmp_wr_any) begin
            st_d.busy = 1'b0;
        end
        if (wr_cmp_lo_i) begin
            st_d.cmp[DATA_W-1:0] = wdata_i;
        end
        if (wr_cmp_hi_i) begin
            st_d.cmp[CNT_W-1:DATA_W] = wdata_i;
        end
        if (wr_step_i) begin
            st_d.step = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o   = st_q.ctrl;
    assign status_o = st_q.status;
    assign cmp_o    = st_q.cmp;
    assign step_o   = st_q.step;
    assign irq_o    = st_q.status && st_q.ctrl.irq_en;

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o && !wr_stat_i) |=> status_o); // R4

    AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && ctrl_o.cmp_en && (cnt_i >= cmp_o) && !st_q.busy) |=> status_o); // R7

    AST_FAST_PAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit && ctrl_o.auto_en && step_nz && (gap < step_ext) && !cmp_wr_any)
        |=> (cmp_o > $past(cnt_i))); // R5

    AST_CMP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(ctrl_o.auto_en && step_nz) && !st_q.busy && !wr_cmp_lo_i && !wr_cmp_hi_i)
        |=> $stable(cmp_o)); // R5

endmodule

// File: rtl/mc_global_timer.sv
module mc_global_timer
    import gt_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int DATA_W    = 32,
    parameter int PRE_W     = 8,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int CNT_W    = 2 * DATA_W
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 bus_valid_i,
    input  logic                 bus_write_i,
    input  logic [4:0]           bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    input  logic [CORE_W-1:0]    bus_core_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic [NUM_CORES-1:0] irq_o
);

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] presc;
    } glob_t;

    glob_t g_d, g_q;

    logic [2:0]  word;
    logic        acc_ok;
    logic        wr_ok;
    logic        rd_ok;
    logic [CNT_W-1:0] cnt;

    bank_ctrl_t        bk_ctrl   [NUM_CORES];
    logic              bk_status [NUM_CORES];
    logic [CNT_W-1:0]  bk_cmp    [NUM_CORES];
    logic [DATA_W-1:0] bk_step   [NUM_CORES];

    assign word   = bus_addr_i[4:2];
    assign acc_ok = bus_valid_i && (bus_addr_i[1:0] == 2'b00)
                    && (int'(bus_core_i) < NUM_CORES);
    assign wr_ok  = acc_ok && bus_write_i;
    assign rd_ok  = acc_ok && !bus_write_i;

    // Shared control fields
    always_comb begin
        g_d = g_q;
        if (wr_ok && word == W_CTRL) begin
            g_d.run   = bus_wdata_i[B_RUN];
            g_d.presc = bus_wdata_i[B_PRE_LSB +: PRE_W];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    gt_counter #(
        .DATA_W (DATA_W),
        .PRE_W  (PRE_W)
    ) u_counter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (g_q.run),
        .presc_i (g_q.presc),
        .wr_lo_i (wr_ok && word == W_CNT_LO),
        .wr_hi_i (wr_ok && word == W_CNT_HI),
        .wdata_i (bus_wdata_i),
        .cnt_o   (cnt)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_bank
        logic mine;
        assign mine = wr_ok && (int'(bus_core_i) == c);

        gt_bank #(
            .DATA_W (DATA_W)
        ) u_bank (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .run_i       (g_q.run),
            .cnt_i       (cnt),
            .wdata_i     (bus_wdata_i),
            .wr_ctrl_i   (mine && word == W_CTRL),
            .wr_stat_i   (mine && word == W_STATUS),
            .wr_cmp_lo_i (mine && word == W_CMP_LO),
            .wr_cmp_hi_i (mine && word == W_CMP_HI),
            .wr_step_i   (mine && word == W_STEP),
            .ctrl_o      (bk_ctrl[c]),
            .status_o    (bk_status[c]),
            .cmp_o       (bk_cmp[c]),
            .step_o      (bk_step[c]),
            .irq_o       (irq_o[c])
        );
    end

    // Read path: select the addressed bank, then the addressed word
    bank_ctrl_t        s_ctrl;
    logic              s_status;
    logic [CNT_W-1:0]  s_cmp;
    logic [DATA_W-1:0] s_step;

    always_comb begin
        s_ctrl   = '0;
        s_status = 1'b0;
        s_cmp    = '0;
        s_step   = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (int'(bus_core_i) == c) begin
                s_ctrl   = bk_ctrl[c];
                s_status = bk_status[c];
                s_cmp    = bk_cmp[c];
                s_step   = bk_step[c];
            end
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (rd_ok) begin
            case (word)
                W_CNT_LO: bus_rdata_o = cnt[DATA_W-1:0];
                W_CNT_HI: bus_rdata_o = cnt[CNT_W-1:DATA_W];
                W_CTRL: begin
                    bus_rdata_o[B_RUN]                 = g_q.run;
                    bus_rdata_o[B_PRE_LSB +: PRE_W]    = g_q.presc;
                    bus_rdata_o[B_CMP_EN]              = s_ctrl.cmp_en;
                    bus_rdata_o[B_IRQ_EN]              = s_ctrl.irq_en;
                    bus_rdata_o[B_AUTO]                = s_ctrl.auto_en;
                end
                W_STATUS: bus_rdata_o[0] = s_status;
                W_CMP_LO: bus_rdata_o = s_cmp[DATA_W-1:0];
                W_CMP_HI: bus_rdata_o = s_cmp[CNT_W-1:DATA_W];
                W_STEP:   bus_rdata_o = s_step;
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    AST_RD_HOLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_valid_i && !bus_write_i && (bus_addr_i[1:0] != 2'b00 || bus_addr_i[4:2] == 3'd7))
        |-> (bus_rdata_o == '0)); // R9

    AST_CTRL_HOLE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(bus_valid_i && bus_write_i && bus_addr_i == 5'h08)) |=> $stable(g_q)); // R8

endmodule

// File: tb/mc_global_timer_tb.sv
module mc_global_timer_tb;

    localparam int NC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic        write = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [0:0]  core = '0;
    logic [31:0] rdata;
    logic [NC-1:0] irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    mc_global_timer #(.NUM_CORES(NC)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_valid_i (valid),
        .bus_write_i (write),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_core_i  (core),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input int c);
        @(negedge clk);
        valid = 1'b1; write = 1'b1; addr = a; wdata = d; core = 1'(c);
        @(negedge clk);
        valid = 1'b0; write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input int c, output logic [31:0] d);
        @(negedge clk);
        valid = 1'b1; write = 1'b0; addr = a; core = 1'(c);
        #1 d = rdata;
        valid = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(5'h00, 0, v); chk("R10 cnt lo", v, 0);
        rd(5'h04, 0, v); chk("R10 cnt hi", v, 0);
        rd(5'h08, 1, v); chk("R10 ctrl", v, 0);
        rd(5'h0C, 0, v); chk("R10 status", v, 0);
        rd(5'h10, 1, v); chk("R10 cmp", v, 0);
        chk("R10 irq", 32'(irq), 0);
    endtask

    task automatic t_carry;
        logic [31:0] v;
        wr(5'h00, 32'hFFFF_FFFE, 0);
        wr(5'h04, 32'h0000_0001, 0);
        rd(5'h00, 0, v); chk("R1 load lo", v, 32'hFFFF_FFFE);
        rd(5'h04, 0, v); chk("R1 load hi", v, 32'h1);
        wr(5'h08, 32'h1, 0);         // run, prescale 0
        idle(1);
        wr(5'h08, 32'h0, 0);         // 3 counting edges in total
        rd(5'h00, 0, v); chk("R1 carry lo", v, 32'h1);
        rd(5'h04, 0, v); chk("R1 carry hi", v, 32'h2);
    endtask

    task automatic t_presc;
        logic [31:0] v;
        wr(5'h00, 0, 0); wr(5'h04, 0, 0);
        wr(5'h08, 32'h0301, 0);      // P=3
        idle(10);
        wr(5'h08, 32'h0300, 0);      // 12 edges -> 3 counts
        rd(5'h00, 0, v); chk("R2 prescale 3", v, 3);
    endtask

    task automatic t_wr_ignored;
        logic [31:0] v;
        wr(5'h08, 32'hFF01, 0);      // slow run, no count in a few edges
        wr(5'h00, 32'h1234, 1);
        wr(5'h04, 32'h55, 0);
        wr(5'h08, 32'hFF00, 0);
        rd(5'h00, 0, v); chk("R3 lo kept", v, 3);
        rd(5'h04, 0, v); chk("R3 hi kept", v, 0);
    endtask

    task automatic t_compare;
        logic [31:0] v;
        wr(5'h00, 0, 0);
        wr(5'h10, 10, 0);
        wr(5'h14, 0, 0);
        wr(5'h08, 32'h7, 0);         // run, cmp_en, irq_en on core 0
        idle(5);
        rd(5'h0C, 0, v); chk("R4 before match", v, 0);
        chk("R6 irq before", 32'(irq), 0);
        idle(10);
        rd(5'h0C, 0, v); chk("R4 after match", v, 1);
        chk("R6 irq core0 only", 32'(irq), 32'b01);
        rd(5'h0C, 1, v); chk("R8 core1 status", v, 0);
        wr(5'h08, 32'h6, 0);         // stop
        rd(5'h0C, 0, v); chk("R4 sticky", v, 1);
        wr(5'h0C, 0, 0);
        rd(5'h0C, 0, v); chk("R7 write 0 keeps", v, 1);
        wr(5'h0C, 1, 0);
        rd(5'h0C, 0, v); chk("R7 write 1 clears", v, 0);
        chk("R6 irq after clear", 32'(irq), 0);
    endtask

    task automatic t_gate;
        logic [31:0] v;
        wr(5'h10, 0, 0);             // comparator below count: ge match
        wr(5'h08, 32'h3, 0);         // run, cmp_en, no irq_en
        idle(3);
        rd(5'h0C, 0, v); chk("R4 ge match", v, 1);
        chk("R6 gated off", 32'(irq), 0);
        wr(5'h08, 32'h7, 0);
        chk("R6 gated on", 32'(irq), 32'b01);
        wr(5'h08, 32'h0, 0);
        wr(5'h0C, 1, 0);
    endtask

    task automatic t_bank;
        logic [31:0] v;
        wr(5'h08, 32'h0006, 0);
        wr(5'h08, 32'h0508, 1);
        rd(5'h08, 0, v); chk("R8 core0 view", v, 32'h0506);
        rd(5'h08, 1, v); chk("R8 core1 view", v, 32'h0508);
        wr(5'h08, 32'h0, 1);
        wr(5'h08, 32'h0, 0);
    endtask

    task automatic t_auto_fast;
        logic [31:0] v;
        wr(5'h00, 0, 0);
        wr(5'h10, 4, 0);
        wr(5'h18, 10, 0);
        wr(5'h0C, 1, 0);
        wr(5'h08, 32'hB, 0);         // run, cmp_en, auto
        idle(18);
        wr(5'h08, 32'hA, 0);         // 20 counting edges
        rd(5'h00, 0, v); chk("R5 fast count", v, 20);
        rd(5'h10, 0, v); chk("R5 fast cmp", v, 24);
        rd(5'h0C, 0, v); chk("R4 fast flag", v, 1);
    endtask

    task automatic t_auto_slow;
        logic [31:0] v;
        wr(5'h08, 0, 0);
        wr(5'h0C, 1, 0);
        wr(5'h00, 1000, 0);
        wr(5'h10, 3, 0);
        wr(5'h18, 7, 0);
        wr(5'h08, 32'hFF0B, 0);
        idle(100);
        wr(5'h08, 32'hFF0A, 0);
        rd(5'h00, 0, v); chk("R5 slow count frozen", v, 1000);
        rd(5'h10, 0, v); chk("R5 slow cmp", v, 1004);
        rd(5'h14, 0, v); chk("R5 slow cmp hi", v, 0);
    endtask

    task automatic t_auto_zero;
        logic [31:0] v;
        wr(5'h0C, 1, 0);
        wr(5'h10, 3, 0);
        wr(5'h18, 0, 0);
        wr(5'h08, 32'hFF0B, 0);
        idle(10);
        wr(5'h08, 32'hFF0A, 0);
        rd(5'h10, 0, v); chk("R5 zero step cmp", v, 3);
        rd(5'h0C, 0, v); chk("R4 zero step flag", v, 1);
    endtask

    task automatic t_holes;
        logic [31:0] v;
        rd(5'h1C, 0, v); chk("R9 hole read", v, 0);
        rd(5'h09, 0, v); chk("R9 misaligned read", v, 0);
        wr(5'h09, 32'h1, 0);
        wr(5'h1C, 32'hFFFF_FFFF, 0);
        rd(5'h08, 0, v); chk("R9 misaligned write", v, 32'hFF0A);
        rd(5'h00, 0, v); chk("R9 count untouched", v, 1000);
    endtask

    task automatic t_per_core;
        logic [31:0] v;
        wr(5'h18, 32'h55, 1);
        wr(5'h14, 32'hABCD, 1);
        rd(5'h18, 0, v); chk("R11 core0 step", v, 0);
        rd(5'h18, 1, v); chk("R11 core1 step", v, 32'h55);
        rd(5'h14, 1, v); chk("R11 core1 cmp hi", v, 32'hABCD);
        rd(5'h14, 0, v); chk("R11 core0 cmp hi", v, 0);
    endtask

    task automatic t_reset_again;
        logic [31:0] v;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(5'h00, 0, v); chk("R10 count cleared", v, 0);
        rd(5'h14, 1, v); chk("R10 cmp cleared", v, 0);
        rd(5'h18, 1, v); chk("R10 step cleared", v, 0);
        rd(5'h08, 0, v); chk("R10 ctrl cleared", v, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_carry();
        t_presc();
        t_wr_ignored();
        t_compare();
        t_gate();
        t_bank();
        t_auto_fast();
        t_auto_slow();
        t_auto_zero();
        t_holes();
        t_per_core();
        t_reset_again();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule